// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Controller

This block is the device-side logic of a small serial EEPROM with a select line, a serial clock, a data input and a data output that can be released. It holds 1024 words of 16 bits. A host selects the device, clocks in a start bit, a two-bit opcode and a ten-bit word address, and then either streams words out, supplies a data word to program, or sets or clears a write-permission latch. All logic runs on a fast system clock. The serial clock and the data inputs are treated as synchronous levels, and a rising edge of the serial clock is detected in the system clock domain.

A write is committed only when the permission latch is set. The programming step starts when the select line drops after a complete write frame. It then runs for a fixed number of system clock cycles, set by a parameter. While the select line is high, the data output shows 0 during programming and 1 once the word is stored. The 1 stays on the output until the next start bit arrives.

Controller states: IDLE (waiting for a start bit), OPCODE (taking two opcode bits), ADDRESS (taking ten address bits), WDATA (taking sixteen data bits), READ (streaming words), HOLD (frame complete, waiting for the select line to drop), BUSY (programming) and READY (status shown). Transitions: IDLE to OPCODE on a 1 bit. OPCODE to ADDRESS after two bits. ADDRESS goes to READ, WDATA or HOLD after ten bits, depending on the opcode. WDATA to HOLD after sixteen bits. HOLD to BUSY when the select line drops with a write pending, otherwise HOLD to IDLE. BUSY to READY when the timer expires. READY to OPCODE on a start bit. OPCODE, ADDRESS, WDATA and READ go back to IDLE when the select line drops.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset, do_en is 0 and the write-permission latch is cleared. A complete write frame sent before any enable frame leaves the stored word unchanged.
- R2: do_en is 0 in every cycle in which cs is 0.
- R3: A frame begins with the first 1 sampled on a serial-clock rising edge while cs is 1. Zeros before that bit are ignored. The start bit is followed by a 2-bit opcode and then a 10-bit address, both MSB first.
- R4: Opcode 10 reads. After the last address bit, data out shows a single 0, then on each further serial-clock rising edge it shows the next data bit, MSB first.
- R5: Continued clocking during a read streams the following words with no gap bit, and the address wraps from 1023 to 0.
- R6: Opcode 01 takes 16 data bits MSB first. If the latch is set, dropping cs after the last bit programs the word at the given address.
- R7: A write frame received while the latch is clear changes nothing and produces no status output.
- R8: Opcode 00 with address bits [9:8] = 11 sets the latch, and with [9:8] = 00 clears it. Reads work in either latch state.
- R9: Programming lasts PROG_CYCLES system clock cycles from the cycle after cs drops. Throughout that time, whenever cs is 1, do_en is 1 and do_val is 0.
- R10: Once programming ends, do_val is 1 whenever cs is 1. This holds across cs low periods until a start bit is received.
- R11: Serial-clock activity during programming is ignored, including a complete disable frame.
- R12: A frame cut short by cs going low is discarded. A partial write programs nothing and produces no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Device select, active high |
| sk | input | 1 | Serial clock level, sampled by clk |
| di | input | 1 | Serial data input |
| do_val | output | 1 | Serial data output value |
| do_en | output | 1 | Output enable for do_val; 0 means released (high impedance) |

## Verification
A behavioural model in the bench tracks every frame and is compared with both outputs on every system clock. Directed reads cover several patterns:
- single words with alternating and mixed bit patterns, which expose a wrong bit order or a missing dummy bit;
- a three-word stream across address 1023, which shows whether the address advances and wraps;
- a frame preceded by idle zeros, which tells start detection apart from fixed framing.

Write sequences cover the latch states:
- writes with the latch clear, which must leave the old word in place;
- a disable frame sent during programming, which must not clear the latch;
- a write cut off after eight data bits, which must neither program the word nor show status.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDRESS,
        ST_WDATA,
        ST_READ,
        ST_HOLD,
        ST_BUSY,
        ST_READY
    } mw_state_t;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_CTRL  = 2'b00;
endpackage

// File: rtl/mw_sk_edge.sv
module mw_sk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sk,
    output logic sk_rise
);
    logic sk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_q <= 1'b0;
        else        sk_q <= sk;
    end

    assign sk_rise = sk & ~sk_q;

    // R3: one serial-clock rising edge yields exactly one sampling cycle
    a_r3_single_sample: assert property (@(posedge clk) disable iff (!rst_n)
        sk_rise |=> !sk_rise);
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int TW = $clog2(PROG_CYCLES + 1);

    logic [TW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              remain <= '0;
        else if (start)          remain <= TW'(PROG_CYCLES);
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign done = (remain == TW'(1));

    // R9: the end of programming is signalled for a single cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_val,
    output logic do_en
);
    import mw_pkg::*;

    localparam int CNT_W = $clog2(DATA_W) + 1;

    mw_state_t         state, nxt;
    logic              sk_rise, take, tmr_done, tmr_start, mem_we;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        opc;
    logic [ADDR_W-1:0] addr, addr_nx, rd_addr, raddr;
    logic [DATA_W-1:0] wbuf, rd_sh, rdata;
    logic              wen, wr_pend, do_q;
    logic              last_opc, last_addr, last_data;

    mw_sk_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sk      (sk),
        .sk_rise (sk_rise)
    );

    mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (addr),
        .wdata (wbuf),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign take      = cs & sk_rise;
    assign addr_nx   = {addr[ADDR_W-2:0], di};
    assign last_opc  = (cnt == CNT_W'(1));
    assign last_addr = (cnt == CNT_W'(ADDR_W - 1));
    assign last_data = (cnt == CNT_W'(DATA_W - 1));
    assign raddr     = (state == ST_ADDRESS) ? addr_nx : rd_addr;
    assign tmr_start = (state == ST_HOLD) && !cs && wr_pend;
    assign mem_we    = (state == ST_BUSY) && tmr_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (take && di) nxt = ST_OPCODE;
            ST_OPCODE:  if (!cs) nxt = ST_IDLE;
                        else if (take && last_opc) nxt = ST_ADDRESS;
            ST_ADDRESS: if (!cs) nxt = ST_IDLE;
                        else if (take && last_addr) begin
                            if (opc == OPC_READ)       nxt = ST_READ;
                            else if (opc == OPC_WRITE) nxt = ST_WDATA;
                            else                       nxt = ST_HOLD;
                        end
            ST_WDATA:   if (!cs) nxt = ST_IDLE;
                        else if (take && last_data) nxt = ST_HOLD;
            ST_READ:    if (!cs) nxt = ST_IDLE;
            ST_HOLD:    if (!cs) nxt = wr_pend ? ST_BUSY : ST_IDLE;
            ST_BUSY:    if (tmr_done) nxt = ST_READY;
            ST_READY:   if (take && di) nxt = ST_OPCODE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            opc     <= '0;
            addr    <= '0;
            wbuf    <= '0;
            rd_sh   <= '0;
            rd_addr <= '0;
            wen     <= 1'b0;
            wr_pend <= 1'b0;
            do_q    <= 1'b0;
        end else begin
            if (state != nxt && state != ST_ADDRESS) cnt <= '0;
            else if (take) cnt <= cnt + 1'b1;

            if (take) begin
                unique case (state)
                    ST_OPCODE: opc <= {opc[0], di};
                    ST_ADDRESS: begin
                        addr <= addr_nx;
                        if (last_addr) begin
                            cnt     <= '0;
                            wr_pend <= 1'b0;
                            if (opc == OPC_READ) begin
                                do_q    <= 1'b0;
                                rd_sh   <= rdata;
                                rd_addr <= addr_nx + 1'b1;
                            end else if (opc == OPC_CTRL) begin
                                if (addr_nx[ADDR_W-1 -: 2] == 2'b11) wen <= 1'b1;
                                else if (addr_nx[ADDR_W-1 -: 2] == 2'b00) wen <= 1'b0;
                            end
                        end
                    end
                    ST_WDATA: begin
                        wbuf <= {wbuf[DATA_W-2:0], di};
                        if (last_data) wr_pend <= wen;
                    end
                    ST_READ: begin
                        do_q <= rd_sh[DATA_W-1];
                        if (last_data) begin
                            cnt     <= '0;
                            rd_sh   <= rdata;
                            rd_addr <= rd_addr + 1'b1;
                        end else begin
                            rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
                        end
                    end
                    default: ;
                endcase
            end

            if (mem_we) wr_pend <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        do_en  = 1'b0;
        do_val = 1'b0;
        unique case (state)
            ST_READ:  begin do_en = cs; do_val = do_q; end
            ST_BUSY:  begin do_en = cs; do_val = 1'b0; end
            ST_READY: begin do_en = cs; do_val = 1'b1; end
            default:  ;
        endcase
    end

    // R6: a complete permitted write starts programming when cs drops
    a_r6_prog_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !cs && wr_pend) |=> (state == ST_BUSY));
    // R7: the array is only written while the latch is set
    a_r7_write_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wen);
    // R11: programming cannot be left except towards status
    a_r11_busy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |=> (state == ST_BUSY || state == ST_READY));
    // R10: status persists until a start bit
    a_r10_status_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && !(take && di)) |=> (state == ST_READY));
    // R11: the latch cannot change during programming
    a_r11_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |=> $stable(wen));
endmodule

// File: tb/mw_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module mw_eeprom_slave_tb_top;
    localparam int PROG = 120;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_val, do_en;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mw_eeprom_slave #(.PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .do_val(do_val), .do_en(do_en)
    );

    // ---------------- behavioural reference model ----------------
    localparam int M_IDLE = 0, M_OPC = 1, M_ADR = 2, M_WD = 3,
                   M_RD = 4, M_HOLD = 5, M_BUSY = 6, M_RDY = 7;
    int model_mem [1024];
    int mode = M_IDLE, nb = 0, op = 0, adr = 0, dat = 0, wait_left = 0;
    int rd_ptr = 0, rd_pos = 0;
    bit latch = 0, pend = 0, mout = 0, skp = 0;

    initial for (int i = 0; i < 1024; i++) model_mem[i] = 0;

    always @(posedge clk) begin
        bit rise, tk, exp_en, exp_val;
        if (!rst_n) begin
            mode = M_IDLE; latch = 0; pend = 0; mout = 0; skp = 0;
        end else begin
            rise = sk && !skp;
            skp  = sk;
            tk   = cs && rise;
            case (mode)
                M_IDLE: if (tk && di) begin mode = M_OPC; nb = 0; op = 0; end
                M_RDY:  if (tk && di) begin mode = M_OPC; nb = 0; op = 0; end
                M_OPC: if (!cs) mode = M_IDLE;
                       else if (tk) begin
                           op = op * 2 + int'(di); nb++;
                           if (nb == 2) begin mode = M_ADR; nb = 0; adr = adr; end
                       end
                M_ADR: if (!cs) mode = M_IDLE;
                       else if (tk) begin
                           adr = (adr * 2 + int'(di)) % 1024; nb++;
                           if (nb == 10) begin
                               nb = 0; pend = 0;
                               if (op == 2) begin
                                   mode = M_RD; mout = 0; rd_ptr = adr; rd_pos = 0;
                               end else if (op == 1) begin
                                   mode = M_WD; dat = 0;
                               end else begin
                                   if (op == 0 && adr >= 768) latch = 1;
                                   if (op == 0 && adr < 256)  latch = 0;
                                   mode = M_HOLD;
                               end
                           end
                       end
                M_WD: if (!cs) mode = M_IDLE;
                      else if (tk) begin
                          dat = (dat * 2 + int'(di)) % 65536; nb++;
                          if (nb == 16) begin pend = latch; mode = M_HOLD; end
                      end
                M_RD: if (!cs) mode = M_IDLE;
                      else if (tk) begin
                          mout = ((model_mem[rd_ptr] >> (15 - rd_pos)) & 1) != 0;
                          rd_pos++;
                          if (rd_pos == 16) begin rd_pos = 0; rd_ptr = (rd_ptr + 1) % 1024; end
                      end
                M_HOLD: if (!cs) begin
                            if (pend) begin mode = M_BUSY; wait_left = PROG; end
                            else mode = M_IDLE;
                        end
                M_BUSY: begin
                            wait_left--;
                            if (wait_left == 0) begin
                                model_mem[adr] = dat; pend = 0; mode = M_RDY;
                            end
                        end
                default: mode = M_IDLE;
            endcase
        end
        #5;
        exp_en  = cs && (mode == M_RD || mode == M_BUSY || mode == M_RDY);
        exp_val = (mode == M_RD) ? mout : (mode == M_RDY);
        if (rst_n) begin
            total++;
            if (do_en !== exp_en || (exp_en && do_val !== exp_val)) begin
                bad++;
                $display("FAIL R2 R4 R9 R10 per-cycle model: en=%b val=%b expected en=%b val=%b",
                         do_en, do_val, exp_en, exp_val);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk(input logic b);
        di = b; sk = 1'b1; tick(2);
        sk = 1'b0; tick(2);
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sclk(v[i]);
    endtask

    task automatic ctrl(input logic [1:0] hi);
        cs = 1'b1; tick(2);
        send({1'b1, 2'b00, hi, 8'h00}, 13);
        cs = 1'b0; tick(2);
    endtask

    task automatic write_frame(input int a, input logic [15:0] d);
        cs = 1'b1; tick(2);
        send({1'b1, 2'b01, 10'(a)}, 13);
        send({16'h0, d}, 16);
        cs = 1'b0; tick(2);
    endtask

    task automatic wait_ready;
        cs = 1'b1;
        for (int i = 0; i < 1000; i++) begin
            if (do_en === 1'b1 && do_val === 1'b1) break;
            tick(1);
        end
        cs = 1'b0; tick(2);
    endtask

    task automatic read_words(input int a, input int zeros, input int n,
                              input logic [15:0] e0, input logic [15:0] e1,
                              input logic [15:0] e2, input string tag);
        logic [15:0] w;
        logic [15:0] ev;
        cs = 1'b1; tick(2);
        for (int z = 0; z < zeros; z++) sclk(1'b0);
        send({1'b1, 2'b10, 10'(a)}, 13);
        chk(do_en === 1'b1 && do_val === 1'b0, "R4 dummy bit", int'(do_val), 0);
        for (int k = 0; k < n; k++) begin
            w = '0;
            for (int b = 0; b < 16; b++) begin
                sclk(1'b0);
                w = {w[14:0], do_val};
            end
            ev = (k == 0) ? e0 : (k == 1) ? e1 : e2;
            chk(w === ev, tag, int'(w), int'(ev));
        end
        cs = 1'b0; tick(2);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        chk(do_en === 1'b0, "R1 reset output released", int'(do_en), 0);

        ctrl(2'b11);
        write_frame(5, 16'hA5A5);
        cs = 1'b1; tick(1);
        chk(do_en === 1'b1 && do_val === 1'b0, "R9 busy shown", int'(do_val), 0);
        cs = 1'b0; tick(1);
        wait_ready;
        read_words(5, 0, 1, 16'hA5A5, 16'h0, 16'h0, "R6 R4 stored word");

        write_frame(12, 16'h3C3C);
        wait_ready;
        tick(3);
        chk(do_en === 1'b0, "R2 released while deselected", int'(do_en), 0);
        cs = 1'b1; tick(2);
        chk(do_en === 1'b1 && do_val === 1'b1, "R10 status held", int'(do_val), 1);
        cs = 1'b0; tick(2);

        write_frame(1023, 16'hBEEF); wait_ready;
        write_frame(0, 16'h0F0F);    wait_ready;
        write_frame(1, 16'h1357);    wait_ready;
        read_words(1023, 0, 3, 16'hBEEF, 16'h0F0F, 16'h1357, "R5 stream with wrap");

        read_words(12, 3, 1, 16'h3C3C, 16'h0, 16'h0, "R3 leading zeros ignored");

        ctrl(2'b00);
        write_frame(5, 16'h1234);
        cs = 1'b1; tick(3);
        chk(do_en === 1'b0, "R7 no status after locked write", int'(do_en), 0);
        cs = 1'b0; tick(2);
        read_words(5, 0, 1, 16'hA5A5, 16'h0, 16'h0, "R7 R8 locked write ignored");

        ctrl(2'b11);
        write_frame(9, 16'h5555);
        cs = 1'b1; tick(2);
        send({1'b1, 2'b00, 2'b00, 8'h00}, 13);
        cs = 1'b0; tick(2);
        wait_ready;
        write_frame(10, 16'h6666);
        wait_ready;
        read_words(10, 0, 1, 16'h6666, 16'h0, 16'h0, "R11 disable during busy ignored");
        read_words(9, 0, 1, 16'h5555, 16'h0, 16'h0, "R6 word before disable frame");

        cs = 1'b1; tick(2);
        send({1'b1, 2'b01, 10'd9}, 13);
        send(32'hFF, 8);
        cs = 1'b0; tick(4);
        cs = 1'b1; tick(3);
        chk(do_en === 1'b0, "R12 cut write shows no status", int'(do_en), 0);
        cs = 1'b0; tick(2);
        read_words(9, 0, 1, 16'h5555, 16'h0, 16'h0, "R12 cut write discarded");

        rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(2);
        write_frame(5, 16'hFFFF);
        tick(PROG + 10);
        read_words(5, 0, 1, 16'hA5A5, 16'h0, 16'h0, "R1 latch clear after reset");

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule